// File: doc/BRIEF.md
# Hysteretic Auto-Range Gain Controller

This block selects the gain range of an optical receiver by watching the stream of digitized receiver output samples. Each accepted sample is compared against two run-time thresholds. A sustained excursion above the upper threshold moves the selection one step toward lower gain, before the analog path reaches hard clipping. A sustained excursion below the lower threshold moves it one step toward higher gain. The lower threshold sits under the upper one, so a hysteresis band separates the two decisions.

Hunting near a boundary is suppressed in three ways. A run of consecutive qualifying samples is required before any switch. Gain increases need a run at least as long as gain decreases. After every switch a settling holdoff freezes further decisions. During the holdoff every sample is tagged as unsettled. Each sample leaves the block one clock later with the range index that was active when it was taken and a settled flag, so downstream logic can rescale it or discard it.

Top module: `autorange_ctrl`

## Requirements
- R1: A synchronous reset sets `range_sel` to 0, which is the lowest gain, and clears `out_valid`. The first `hold_len` accepted samples after reset are reported with `out_settled` = 0.
- R2: The index drops by one when `cnt_down` consecutive settled samples are each strictly greater than `thr_hi`. The last of these is the sample that triggers the switch.
- R3: The index rises by one when consecutive settled samples are each strictly less than `thr_lo` and their number reaches the required up-range count.
- R4: A settled sample that does not extend the current run restarts that run from zero. Such a sample is either inside the band (`thr_lo` <= x <= `thr_hi`) or on the opposite side.
- R5: The required up-range count is the larger of `cnt_up` and the effective down-range count. A count of 0 is treated as 1.
- R6: After a switch, the next `hold_len` accepted samples are reported with `out_settled` = 0 and cannot cause a switch. Both runs restart from zero once the holdoff ends.
- R7: The index saturates at 0 and at NUM_RANGES-1. A qualifying request beyond either end leaves the index unchanged and starts no holdoff. The request still restarts its run.
- R8: A sample that is both above `thr_hi` and below `thr_lo` counts as a down-range excursion only. This can happen only when the thresholds are misordered.
- R9: Each accepted sample appears one clock later with `out_valid` = 1, the same data, and the index that was active when it was taken. With `smp_valid` low, `out_valid` is 0 on the next clock and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe; one sample clock per high cycle |
| smp_data | input | SAMPLE_W | Unsigned sample magnitude |
| thr_hi | input | SAMPLE_W | Upper threshold (step gain down above it) |
| thr_lo | input | SAMPLE_W | Lower threshold (step gain up below it) |
| cnt_down | input | CNT_W | Consecutive samples needed to lower gain |
| cnt_up | input | CNT_W | Consecutive samples needed to raise gain |
| hold_len | input | HOLD_W | Settling holdoff in sample clocks |
| range_sel | output | RANGE_W | Active range index driven to the analog switches |
| out_valid | output | 1 | Registered sample strobe |
| out_data | output | SAMPLE_W | Registered sample data |
| out_range | output | RANGE_W | Range index in force when the sample was taken |
| out_settled | output | 1 | Sample was taken outside a settling holdoff |

## Verification
The bench checks that a run broken by a single in-band sample starts over. A design that only counts total excursions would switch too early. A request at either end of the range must not open a holdoff; a design that loads the timer anyway would flag good samples as unsettled. The bench programs an up-range count below the down-range count, where a design without the clamp would raise gain too eagerly. It also misorders the thresholds, where a design without down-range priority would raise gain into clipping. Finally it checks the tag of the very sample that causes a switch. That sample must carry the old index and be marked settled, so an off-by-one in the output register or the holdoff load shows up there.

// File: rtl/ar_pkg.sv
package ar_pkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_HIGH = 2'd1,
    EXC_LOW  = 2'd2
  } excursion_e;

  localparam int DIR_DOWN = 0;
  localparam int DIR_UP   = 1;
  localparam int NUM_DIRS = 2;
endpackage

// File: rtl/ar_classify.sv
module ar_classify
  import ar_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] data,
  input  logic [SAMPLE_W-1:0] thr_hi,
  input  logic [SAMPLE_W-1:0] thr_lo,
  output excursion_e          exc
);
  // High side is tested first: saturation protection outranks gain increase (R8).
  always_comb begin
    if (data > thr_hi)      exc = EXC_HIGH;
    else if (data < thr_lo) exc = EXC_LOW;
    else                    exc = EXC_NONE;
  end
endmodule

// File: rtl/ar_debounce.sv
module ar_debounce #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             hit,
  input  logic             clear,
  input  logic [CNT_W-1:0] need,
  output logic             fire
);
  logic [CNT_W-1:0] run;
  logic [CNT_W-1:0] run_inc;

  assign run_inc = (run == {CNT_W{1'b1}}) ? run : run + 1'b1;
  assign fire    = step && hit && (run_inc >= need);

  always_ff @(posedge clk) begin
    if (rst)        run <= '0;
    else if (clear) run <= '0;
    else if (step)  run <= hit ? run_inc : '0;
  end

  // R4: a settled sample that misses this direction restarts the run
  assert_run_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !hit) |=> (run == '0));

  // R6: a cleared run restarts at zero
  assert_run_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clear |=> (run == '0));
endmodule

// File: rtl/ar_holdoff.sv
module ar_holdoff #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              tick,
  input  logic [HOLD_W-1:0] len,
  output logic              busy
);
  logic [HOLD_W-1:0] cnt;

  assign busy = (cnt != '0);

  // Reset loads the holdoff so the first data after reset is unsettled (R1).
  always_ff @(posedge clk) begin
    if (rst)               cnt <= len;
    else if (load)         cnt <= len;
    else if (tick && busy) cnt <= cnt - 1'b1;
  end

  // R6: a nonzero holdoff loaded by a switch is active on the next cycle
  assert_hold_start_R6: assert property (@(posedge clk) disable iff (rst)
    (load && len != '0) |=> busy);

  // R9: the timer only advances on sample clocks
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/ar_range.sv
module ar_range #(
  parameter int NUM_RANGES = 6,
  localparam int RANGE_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dec_req,
  input  logic               inc_req,
  output logic [RANGE_W-1:0] idx,
  output logic               switched
);
  localparam logic [RANGE_W-1:0] MAX_IDX = RANGE_W'(NUM_RANGES - 1);

  logic can_dec;
  logic can_inc;

  assign can_dec  = dec_req && (idx != '0);
  assign can_inc  = inc_req && !dec_req && (idx != MAX_IDX);
  assign switched = can_dec || can_inc;

  always_ff @(posedge clk) begin
    if (rst)          idx <= '0;
    else if (can_dec) idx <= idx - 1'b1;
    else if (can_inc) idx <= idx + 1'b1;
  end

  // R7: index never leaves the legal span
  assert_idx_bound_R7: assert property (@(posedge clk) disable iff (rst)
    idx <= MAX_IDX);

  // R7: requests at the ends leave the index alone
  assert_idx_floor_R7: assert property (@(posedge clk) disable iff (rst)
    (idx == '0 && !inc_req) |=> (idx == '0));

  // R8: with both requests present, the index falls
  assert_dec_priority_R8: assert property (@(posedge clk) disable iff (rst)
    (dec_req && inc_req && idx != '0) |=> (idx == $past(idx) - 1'b1));
endmodule

// File: rtl/autorange_ctrl.sv
module autorange_ctrl
  import ar_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int NUM_RANGES = 6,
  parameter int CNT_W      = 8,
  parameter int HOLD_W     = 16,
  localparam int RANGE_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] thr_hi,
  input  logic [SAMPLE_W-1:0] thr_lo,
  input  logic [CNT_W-1:0]    cnt_down,
  input  logic [CNT_W-1:0]    cnt_up,
  input  logic [HOLD_W-1:0]   hold_len,
  output logic [RANGE_W-1:0]  range_sel,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic [RANGE_W-1:0]  out_range,
  output logic                out_settled
);
  excursion_e       exc;
  logic             busy;
  logic             accept;
  logic             clear_runs;
  logic             switched;
  logic [CNT_W-1:0] need_dn;
  logic [CNT_W-1:0] need_up;
  logic [NUM_DIRS-1:0]  fire;
  logic [NUM_DIRS-1:0]  hit;
  logic [CNT_W-1:0] need [NUM_DIRS];

  ar_classify #(.SAMPLE_W(SAMPLE_W)) u_cls (
    .data(smp_data), .thr_hi(thr_hi), .thr_lo(thr_lo), .exc(exc)
  );

  ar_holdoff #(.HOLD_W(HOLD_W)) u_hold (
    .clk(clk), .rst(rst), .load(switched), .tick(smp_valid),
    .len(hold_len), .busy(busy)
  );

  // Decisions are made only on samples outside the holdoff.
  assign accept = smp_valid && !busy;

  // Zero counts mean one; up-range never needs fewer samples than down-range (R5).
  assign need_dn = (cnt_down == '0) ? CNT_W'(1) : cnt_down;
  assign need_up = (cnt_up > need_dn) ? cnt_up : need_dn;

  assign hit[DIR_DOWN]  = (exc == EXC_HIGH);
  assign hit[DIR_UP]    = (exc == EXC_LOW);
  assign need[DIR_DOWN] = need_dn;
  assign need[DIR_UP]   = need_up;

  // Runs restart during holdoff and whenever either direction qualifies.
  assign clear_runs = smp_valid && (busy || (|fire));

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    ar_debounce #(.CNT_W(CNT_W)) u_deb (
      .clk(clk), .rst(rst), .step(accept), .hit(hit[d]),
      .clear(clear_runs), .need(need[d]), .fire(fire[d])
    );
  end

  ar_range #(.NUM_RANGES(NUM_RANGES)) u_rng (
    .clk(clk), .rst(rst),
    .dec_req(fire[DIR_DOWN]), .inc_req(fire[DIR_UP]),
    .idx(range_sel), .switched(switched)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_range   <= '0;
      out_settled <= 1'b0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) begin
        out_data    <= smp_data;
        out_range   <= range_sel;
        out_settled <= !busy;
      end
    end
  end

  // R2: gain only falls after a high excursion on a settled sample
  assert_down_cause_R2: assert property (@(posedge clk) disable iff (rst)
    (range_sel < $past(range_sel)) |-> $past(accept && exc == EXC_HIGH));

  // R3: gain only rises after a low excursion on a settled sample
  assert_up_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (range_sel > $past(range_sel)) |-> $past(accept && exc == EXC_LOW));

  // R9: each sample emerges one clock later tagged with the index it saw
  assert_tag_latency_R9: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> (out_valid && out_range == $past(range_sel)
                   && out_data == $past(smp_data)));

  // R9: no sample clock, no range movement
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> (!out_valid && $stable(range_sel)));
endmodule

// File: tb/tb_autorange_ctrl.sv
module tb_autorange_ctrl;
  localparam int SAMPLE_W   = 16;
  localparam int NUM_RANGES = 6;
  localparam int CNT_W      = 8;
  localparam int HOLD_W     = 16;
  localparam int RANGE_W    = $clog2(NUM_RANGES);
  localparam int MAXR       = NUM_RANGES - 1;
  localparam int CNT_SAT    = (1 << CNT_W) - 1;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                smp_valid = 1'b0;
  logic [SAMPLE_W-1:0] smp_data = '0;
  logic [SAMPLE_W-1:0] thr_hi = 16'd40000;
  logic [SAMPLE_W-1:0] thr_lo = 16'd10000;
  logic [CNT_W-1:0]    cnt_down = 8'd3;
  logic [CNT_W-1:0]    cnt_up = 8'd5;
  logic [HOLD_W-1:0]   hold_len = 16'd4;
  logic [RANGE_W-1:0]  range_sel;
  logic                out_valid;
  logic [SAMPLE_W-1:0] out_data;
  logic [RANGE_W-1:0]  out_range;
  logic                out_settled;

  int checks = 0;
  int errors = 0;
  int m_rng, m_hold, m_dn, m_up;

  always #10 clk = ~clk;

  autorange_ctrl #(
    .SAMPLE_W(SAMPLE_W), .NUM_RANGES(NUM_RANGES), .CNT_W(CNT_W), .HOLD_W(HOLD_W)
  ) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .cnt_down(cnt_down), .cnt_up(cnt_up),
    .hold_len(hold_len), .range_sel(range_sel), .out_valid(out_valid),
    .out_data(out_data), .out_range(out_range), .out_settled(out_settled)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int need_down();
    return (cnt_down == 0) ? 1 : int'(cnt_down);
  endfunction

  function automatic int need_upc();
    int nd = need_down();
    return (int'(cnt_up) > nd) ? int'(cnt_up) : nd;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    smp_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_rng = 0; m_hold = int'(hold_len); m_dn = 0; m_up = 0;
    chk("R1", "range_sel after reset", int'(range_sel), 0);
    chk("R1", "out_valid after reset", int'(out_valid), 0);
  endtask

  // Drive one cycle (called at a negedge), advance the model, check at the next negedge.
  task automatic step(input bit v, input int d, input string req);
    int  e_tag;
    bit  e_set;
    bit  above, below;
    smp_valid = v;
    smp_data  = SAMPLE_W'(d);
    e_tag = m_rng;
    e_set = (m_hold == 0);
    if (v) begin
      if (m_hold != 0) begin
        m_hold--; m_dn = 0; m_up = 0;
      end else begin
        above = (d > int'(thr_hi));
        below = !above && (d < int'(thr_lo));
        if (above) begin
          m_dn = (m_dn < CNT_SAT) ? m_dn + 1 : m_dn; m_up = 0;
        end else if (below) begin
          m_up = (m_up < CNT_SAT) ? m_up + 1 : m_up; m_dn = 0;
        end else begin
          m_dn = 0; m_up = 0;
        end
        if (above && m_dn >= need_down()) begin
          if (m_rng > 0) begin m_rng--; m_hold = int'(hold_len); end
          m_dn = 0; m_up = 0;
        end else if (below && m_up >= need_upc()) begin
          if (m_rng < MAXR) begin m_rng++; m_hold = int'(hold_len); end
          m_dn = 0; m_up = 0;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(req, "out_valid", int'(out_valid), int'(v));
    if (v) begin
      chk(req, "out_data", int'(out_data), d);
      chk(req, "out_range", int'(out_range), e_tag);
      chk(req, "out_settled", int'(out_settled), int'(e_set));
    end
    chk(req, "range_sel", int'(range_sel), m_rng);
  endtask

  task automatic repeat_step(input int n, input int d, input string req);
    for (int i = 0; i < n; i++) step(1'b1, d, req);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    do_reset();

    // R1: first hold_len samples after reset unsettled
    repeat_step(5, 20000, "R1");
    chk("R1", "settled after reset holdoff", int'(out_settled), 1);

    // R7: down requests at the lowest index are ignored and start no holdoff
    repeat_step(3, 50000, "R7");
    step(1'b1, 20000, "R7");
    chk("R7", "no holdoff at floor", int'(out_settled), 1);

    // R9: idle cycles change nothing
    step(1'b0, 0, "R9");
    step(1'b0, 0, "R9");

    // R3 and R6: up-range after cnt_up lows, then holdoff masks samples
    repeat_step(5, 5000, "R3");
    chk("R3", "index rose", int'(range_sel), 1);
    repeat_step(4, 5000, "R6");
    step(1'b1, 20000, "R6");

    // R4: a run broken by an in-band sample restarts
    repeat_step(4, 5000, "R4");
    step(1'b1, 20000, "R4");
    repeat_step(4, 5000, "R4");
    chk("R4", "no switch on broken run", int'(range_sel), 1);
    step(1'b1, 60000, "R4");
    step(1'b1, 20000, "R4");

    // R2: down-range after cnt_down highs
    repeat_step(3, 60000, "R2");
    chk("R2", "index fell", int'(range_sel), 0);
    repeat_step(4, 20000, "R6");

    // R5: cnt_up below cnt_down is clamped up to cnt_down
    @(negedge clk);
    cnt_up = 8'd1; cnt_down = 8'd3;
    repeat_step(2, 100, "R5");
    chk("R5", "no early up-range", int'(range_sel), 0);
    step(1'b1, 100, "R5");
    chk("R5", "up after clamped count", int'(range_sel), 1);
    repeat_step(4, 20000, "R5");
    cnt_down = 8'd0; cnt_up = 8'd0;
    step(1'b1, 100, "R5");
    chk("R5", "zero count acts as one", int'(range_sel), 2);
    repeat_step(4, 20000, "R5");

    // R8: misordered thresholds, both sides hit, down wins
    thr_hi = 16'd20000; thr_lo = 16'd50000;
    step(1'b1, 30000, "R8");
    chk("R8", "down priority", int'(range_sel), 1);
    repeat_step(4, 30000, "R8");
    thr_hi = 16'd40000; thr_lo = 16'd10000;

    // R7: saturate at the top, then a further request starts no holdoff
    hold_len = 16'd0;
    repeat_step(8, 100, "R7");
    chk("R7", "top saturation", int'(range_sel), MAXR);
    step(1'b1, 20000, "R7");
    chk("R7", "no holdoff at ceiling", int'(out_settled), 1);

    // Random phase: mixed traffic and configurations against the model
    hold_len = 16'd3; cnt_down = 8'd2; cnt_up = 8'd4;
    for (int blk = 0; blk < 20; blk++) begin
      thr_hi   = SAMPLE_W'(30000 + $urandom % 30000);
      thr_lo   = SAMPLE_W'(1000 + $urandom % 20000);
      if ($urandom % 8 == 0) thr_lo = SAMPLE_W'(int'(thr_hi) + 100);
      cnt_down = CNT_W'($urandom % 5);
      cnt_up   = CNT_W'($urandom % 7);
      hold_len = HOLD_W'($urandom % 6);
      for (int i = 0; i < 150; i++) begin
        int sel = int'($urandom % 4);
        int d;
        case (sel)
          0:       d = int'(thr_hi) + 1 + int'($urandom % 64);
          1:       d = (thr_lo > 0) ? int'($urandom % int'(thr_lo)) : 0;
          2:       d = int'(thr_lo) + int'($urandom % 64);
          default: d = ($urandom % 2 == 0) ? int'(thr_hi) : int'(thr_lo);
        endcase
        if (d > 65535) d = 65535;
        step(($urandom % 5) != 0, d, "R9");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule